// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-driven management master for PHYs that use the Clause 45 extended addressing scheme. Software first loads the 16-bit number of the target PHY register into a register-number register. It then writes a command register that carries the PHY port address, the device address inside that PHY, a 3-bit command code and, for writes, 16 bits of data. Each accepted command makes the block run two serial frames on the management link without further help from software. The first is an address frame that carries the register number. The second is a data frame that either writes the data or reads it back.

The management clock MDC is derived from the system clock by a parameterised divider and is held low while the link is idle. The block drives MDIO through a separate output and output-enable pair so that a pad or an open-drain cell can be placed outside it. During the read frame it releases the line from the turnaround onwards and samples what the PHY returns on MDC rising edges. Software polls the busy flag in the command register. Once busy is clear and read-valid is set, the read result sits in the low half of the same register.

Top module: `mdio45_master`

## Requirements
- R1: The command register sits at byte offset 0x0 and the register-number register at offset 0x8. Writing offset 0x8 stores bits [15:0], and offset 0x8 reads back as {16'h0, number}. Any other offset reads as zero.
- R2: The command register reads back as bit 31 = 0, bit 30 = busy, bit 29 = read-valid, [28:26] command code, [25:21] device address, [20:16] PHY address, [15:0] data. A write loads the code, the two addresses and the data from the same positions.
- R3: A command code of 5 (write) or 7 (read) written while idle starts an address frame. That frame is 32 ones, start 00, opcode 00, PHY address and device address (5 bits each, MSB first), turnaround 10, and then the 16-bit register number MSB first. MDIO is driven for all 64 bits.
- R4: For code 5 the second frame is 32 ones, start 00, opcode 01, the same addresses, turnaround 10 and the 16 data bits MSB first, all driven. Afterwards the data field still holds the written data.
- R5: For code 7 the second frame carries opcode 11. The block drives its first 46 bits and releases MDIO (output-enable low) for the two turnaround bits and the 16 data bits.
- R6: Busy reads 1 from the first cycle after the accepted command write until the last bit of the second frame. Each command produces exactly 128 MDC rising edges, and busy lasts between 256×MDC_HALF and 256×MDC_HALF+4 clock cycles.
- R7: Read-valid is cleared when a command is accepted and stays 0 while busy. At the end of a read it becomes 1 only if MDIO was sampled 0 on the second turnaround bit. The 16 bits sampled on the MDC rising edges of the data bits (MSB first) are then placed in [15:0]. A write command leaves read-valid at 0.
- R8: Writes to either register while busy is set change nothing and start nothing.
- R9: A command-register write whose code is neither 5 nor 7 is ignored: the register keeps its contents and no MDC edge appears.
- R10: MDC has a period of 2×MDC_HALF clock cycles while a frame runs. When the block is not busy, MDC and the MDIO output-enable are both low.
- R11: After reset, both registers read zero, busy and read-valid are 0, and MDC and output-enable are low. This also holds when reset is applied in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The hardest states to reach from the ports are a failed read, where the PHY answers a 1 in the second turnaround bit, and register traffic that lands while a two-frame sequence is still running. The bench contains a PHY model clocked by MDC. It records every driven bit together with the output-enable state, and it answers read frames with a per-transaction data word and a chosen turnaround bit. For the busy case, the bench issues a conflicting register-number write and a second command straight after an accepted one. It then checks that the recorded frames, the register contents and the MDC edge count all belong only to the first command.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  // register byte offsets
  localparam int OFS_MGMT  = 0;
  localparam int OFS_RNUM  = 8;

  // command register field positions
  localparam int DATA_LSB  = 0;
  localparam int PHY_LSB   = 16;
  localparam int DEV_LSB   = 21;
  localparam int CODE_LSB  = 26;
  localparam int VALID_BIT = 29;
  localparam int BUSY_BIT  = 30;

  // command codes
  localparam logic [2:0] CODE_WRITE = 3'd5;
  localparam logic [2:0] CODE_READ  = 3'd7;

  // frame constants
  localparam logic [1:0] FR_START   = 2'b00;
  localparam logic [1:0] FR_OP_ADDR = 2'b00;
  localparam logic [1:0] FR_OP_WR   = 2'b01;
  localparam logic [1:0] FR_OP_RD   = 2'b11;
  localparam logic [1:0] FR_TURN    = 2'b10;
  localparam int         BODY_BITS  = 32;

  // frame body after the preamble
  function automatic logic [BODY_BITS-1:0] mk_body(input logic [1:0]  op,
                                                   input logic [4:0]  phy,
                                                   input logic [4:0]  dev,
                                                   input logic [15:0] payload);
    return {FR_START, op, phy, dev, FR_TURN, payload};
  endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
  parameter int MDC_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic tick_rise,
  output logic tick_end
);

  localparam int PERIOD = 2 * MDC_HALF;
  localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(MDC_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;

  // a bit cell starts at cnt 0 (MDC low) and MDC is high from CNT_HALF on
  assign tick_rise = run && (cnt_q == CNT_HALF);
  assign tick_end  = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (!run) begin
      cnt_n = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    mdc_n = run && (cnt_n >= CNT_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio45_shift.sv
module mdio45_shift #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               is_read,
  input  logic               tick_rise,
  input  logic               tick_end,
  input  logic               mdio_in,
  output logic               active,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic               done,
  output logic [15:0]        rx_data,
  output logic               ta_ok
);

  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] IDX_TURN  = IDX_W'(FRAME_W - 18);
  localparam logic [IDX_W-1:0] IDX_TURN2 = IDX_W'(FRAME_W - 17);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(FRAME_W - 16);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               act_q, act_n;
  logic               rd_q, rd_n;
  logic [15:0]        rx_q, rx_n;
  logic               ta_q, ta_n;
  logic               smp_en, adv_en;

  assign done   = act_q && tick_end && (idx_q == IDX_LAST);
  assign smp_en = act_q && rd_q && tick_rise;
  assign adv_en = act_q && tick_end;

  always_comb begin
    sh_n  = sh_q;
    idx_n = idx_q;
    act_n = act_q;
    rd_n  = rd_q;
    rx_n  = rx_q;
    ta_n  = ta_q;
    if (start) begin
      sh_n  = frame_in;
      idx_n = '0;
      act_n = 1'b1;
      rd_n  = is_read;
      ta_n  = 1'b0;
    end else begin
      if (smp_en) begin
        if (idx_q == IDX_TURN2) begin
          ta_n = ~mdio_in;
        end
        if (idx_q >= IDX_DATA) begin
          rx_n = {rx_q[14:0], mdio_in};
        end
      end
      if (adv_en) begin
        sh_n  = {sh_q[FRAME_W-2:0], 1'b0};
        idx_n = idx_q + 1'b1;
        if (done) begin
          act_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      rx_q  <= '0;
      ta_q  <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      idx_q <= idx_n;
      act_q <= act_n;
      rd_q  <= rd_n;
      rx_q  <= rx_n;
      ta_q  <= ta_n;
    end
  end

  assign active   = act_q;
  assign mdio_out = act_q & sh_q[FRAME_W-1];
  assign mdio_oe  = act_q && !(rd_q && (idx_q >= IDX_TURN));
  assign rx_data  = rx_q;
  assign ta_ok    = ta_q;

endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
  import mdio45_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PRE_LEN = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      frame_start,
  output logic [PRE_LEN+BODY_BITS-1:0] frame_word,
  output logic                      frame_is_read,
  input  logic                      frame_done,
  input  logic [15:0]               rx_data,
  input  logic                      ta_ok,
  output logic                      busy,
  output logic                      valid,
  output logic [15:0]               rnum
);

  seq_state_e  state_q, state_n;
  logic [15:0] rnum_q, rnum_n;
  logic [15:0] data_q, data_n;
  logic [4:0]  phy_q, phy_n;
  logic [4:0]  dev_q, dev_n;
  logic [2:0]  code_q, code_n;
  logic        valid_q, valid_n;
  logic        start_q, start_n;

  logic        hit_mgmt, hit_rnum, idle, code_ok;
  logic        cmd_take, rnum_take;
  logic [2:0]  cmd_code;
  logic [BODY_BITS-1:0] body;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata[31:29];

  assign idle      = (state_q == SEQ_IDLE);
  assign hit_mgmt  = reg_wr && (reg_addr == ADDR_W'(OFS_MGMT));
  assign hit_rnum  = reg_wr && (reg_addr == ADDR_W'(OFS_RNUM));
  assign cmd_code  = reg_wdata[CODE_LSB +: 3];
  assign code_ok   = (cmd_code == CODE_WRITE) || (cmd_code == CODE_READ);
  assign cmd_take  = idle && hit_mgmt && code_ok;
  assign rnum_take = idle && hit_rnum;

  always_comb begin
    state_n = state_q;
    rnum_n  = rnum_q;
    data_n  = data_q;
    phy_n   = phy_q;
    dev_n   = dev_q;
    code_n  = code_q;
    valid_n = valid_q;
    start_n = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (rnum_take) begin
          rnum_n = reg_wdata[15:0];
        end
        if (cmd_take) begin
          data_n  = reg_wdata[DATA_LSB +: 16];
          phy_n   = reg_wdata[PHY_LSB +: 5];
          dev_n   = reg_wdata[DEV_LSB +: 5];
          code_n  = cmd_code;
          valid_n = 1'b0;
          state_n = SEQ_ADDR;
          start_n = 1'b1;
        end
      end
      SEQ_ADDR: begin
        if (frame_done) begin
          state_n = SEQ_DATA;
          start_n = 1'b1;
        end
      end
      SEQ_DATA: begin
        if (frame_done) begin
          state_n = SEQ_IDLE;
          if (code_q == CODE_READ) begin
            data_n  = rx_data;
            valid_n = ta_ok;
          end
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rnum_q  <= '0;
      data_q  <= '0;
      phy_q   <= '0;
      dev_q   <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_n;
      rnum_q  <= rnum_n;
      data_q  <= data_n;
      phy_q   <= phy_n;
      dev_q   <= dev_n;
      code_q  <= code_n;
      valid_q <= valid_n;
      start_q <= start_n;
    end
  end

  // frame word selected by the phase; held stable while the shifter loads it
  always_comb begin
    if (state_q == SEQ_DATA) begin
      body = mk_body((code_q == CODE_READ) ? FR_OP_RD : FR_OP_WR, phy_q, dev_q, data_q);
    end else begin
      body = mk_body(FR_OP_ADDR, phy_q, dev_q, rnum_q);
    end
  end

  assign frame_word    = {{PRE_LEN{1'b1}}, body};
  assign frame_is_read = (state_q == SEQ_DATA) && (code_q == CODE_READ);
  assign frame_start   = start_q;

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_MGMT)) begin
      reg_rdata = {1'b0, !idle, valid_q, code_q, dev_q, phy_q, data_q};
    end else if (reg_addr == ADDR_W'(OFS_RNUM)) begin
      reg_rdata = {16'h0000, rnum_q};
    end else begin
      reg_rdata = '0;
    end
  end

  assign busy  = !idle;
  assign valid = valid_q;
  assign rnum  = rnum_q;

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master #(
  parameter int MDC_HALF = 25,
  parameter int ADDR_W   = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  localparam int FRAME_W = PRE_LEN + mdio45_pkg::BODY_BITS;

  logic               rst_meta, rst_sync_n;
  logic               frame_start, frame_is_read, frame_done;
  logic [FRAME_W-1:0] frame_word;
  logic [15:0]        rx_data;
  logic               ta_ok;
  logic               link_active, tick_rise, tick_end;
  logic               seq_busy, seq_valid;
  logic [15:0]        seq_rnum;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mdio45_ctrl #(
    .ADDR_W  (ADDR_W),
    .PRE_LEN (PRE_LEN)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .frame_start   (frame_start),
    .frame_word    (frame_word),
    .frame_is_read (frame_is_read),
    .frame_done    (frame_done),
    .rx_data       (rx_data),
    .ta_ok         (ta_ok),
    .busy          (seq_busy),
    .valid         (seq_valid),
    .rnum          (seq_rnum)
  );

  mdio45_shift #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (frame_start),
    .frame_in  (frame_word),
    .is_read   (frame_is_read),
    .tick_rise (tick_rise),
    .tick_end  (tick_end),
    .mdio_in   (mdio_in),
    .active    (link_active),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .done      (frame_done),
    .rx_data   (rx_data),
    .ta_ok     (ta_ok)
  );

  mdio45_clkgen #(
    .MDC_HALF (MDC_HALF)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (link_active),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_end  (tick_end)
  );

endmodule

// File: rtl/mdio45_checker.sv
module mdio45_checker
  import mdio45_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              mdc,
  input logic              mdio_oe,
  input logic              busy,
  input logic              valid,
  input logic [15:0]       rnum
);

  // R6: busy only rises after a write to the command register
  a_r6_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && (reg_addr == ADDR_W'(OFS_MGMT))));

  // R7: read-valid is never set while a sequence runs
  a_r7_valid_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid);

  // R7: read-valid can only appear as the sequence ends
  a_r7_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $fell(busy));

  // R8: register-number register does not move under a write while busy
  a_r8_rnum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(rnum));

  // R10: quiet link when not busy
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

endmodule

bind mdio45_master mdio45_checker #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .mdc      (mdc),
  .mdio_oe  (mdio_oe),
  .busy     (seq_busy),
  .valid    (seq_valid),
  .rnum     (seq_rnum)
);

// File: tb/mdio45_master_test.sv
module mdio45_master_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rises   = 0;
  int rise_c0 = 0;
  int rise_c1 = 0;
  logic [127:0] cap_o, cap_e;
  logic        phy_rd = 1'b0;
  logic        phy_ta = 1'b0;
  logic [15:0] phy_word = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio45_master #(.MDC_HALF(HALF), .ADDR_W(4), .PRE_LEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY-side recorder
  always @(posedge mdc) begin
    if (rises < 128) begin
      cap_o[127-rises] = mdio_out;
      cap_e[127-rises] = mdio_oe;
    end
    if (rises == 0) rise_c0 = cyc;
    if (rises == 1) rise_c1 = cyc;
    rises = rises + 1;
  end

  // PHY-side responder for the read frame
  always @(negedge mdc) begin
    int k;
    k = rises - 64;
    if (phy_rd && k >= 46 && k < 64) begin
      if (k == 46)      mdio_in = 1'b1;
      else if (k == 47) mdio_in = phy_ta;
      else              mdio_in = phy_word[63-k];
    end else begin
      mdio_in = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 1;
    forever begin
      @(negedge clk);
      rd(4'h0, v);
      if (!v[30]) break;
      n++;
    end
  endtask

  function automatic logic [63:0] frm(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] dev, input logic [15:0] pl);
    return {32'hFFFF_FFFF, 2'b00, op, phy, dev, 2'b10, pl};
  endfunction

  task automatic run_txn(input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] rnum,
                         input logic [15:0] wdata, input logic is_rd, input logic ta,
                         input logic [15:0] word);
    logic [31:0] cmd, v;
    logic [63:0] e1, e2;
    int n;
    phy_rd = is_rd; phy_ta = ta; phy_word = word;
    wr(4'h8, {16'hBEEF, rnum});
    cmd = {3'b000, is_rd ? 3'd7 : 3'd5, dev, phy, wdata};
    rises = 0;
    wr(4'h0, cmd);
    rd(4'h0, v);
    chk(v[30] == 1'b1 && v[29] == 1'b0, "R6 busy set, R7 valid cleared on accept", 64'(v[30:29]), 64'h2);
    chk(v[28:0] == cmd[28:0], "R2 command fields readback", 64'(v[28:0]), 64'(cmd[28:0]));
    wait_idle(n);
    chk(n >= 256*HALF && n <= 256*HALF + 4, "R6 busy duration", 64'(n), 64'(256*HALF));
    chk(rises == 128, "R6 MDC edges per command", 64'(rises), 64'd128);
    chk(rise_c1 - rise_c0 == 2*HALF, "R10 MDC period", 64'(rise_c1 - rise_c0), 64'(2*HALF));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle link", {62'd0, mdc, mdio_oe}, 64'd0);
    e1 = frm(2'b00, phy, dev, rnum);
    chk(cap_o[127:64] == e1, "R3 address frame", cap_o[127:64], e1);
    rd(4'h0, v);
    if (!is_rd) begin
      e2 = frm(2'b01, phy, dev, wdata);
      chk(cap_o[63:0] == e2, "R4 write frame", cap_o[63:0], e2);
      chk(&cap_e, "R4 write sequence fully driven", cap_e[127:64] & cap_e[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
      chk(v[29] == 1'b0 && v[15:0] == wdata, "R7 write leaves valid low, R4 data kept", 64'(v[29:0]), 64'(wdata));
    end else begin
      e2 = frm(2'b11, phy, dev, 16'h0000);
      chk(cap_o[63:18] == e2[63:18], "R5 read frame header", 64'(cap_o[63:18]), 64'(e2[63:18]));
      chk(&cap_e[127:18] && cap_e[17:0] == 18'd0, "R5 release after header", cap_e[63:0], 64'hFFFF_FFFF_FFFC_0000);
      chk(v[29] == !ta, "R7 valid from turnaround", 64'(v[29]), 64'(!ta));
      if (!ta) chk(v[15:0] == word, "R7 read data", 64'(v[15:0]), 64'(word));
    end
    chk(v[28:16] == cmd[28:16] && v[31:30] == 2'b00, "R2 fields after completion", 64'(v[31:16]), 64'(cmd[28:16]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, prior, cmd_a;
    logic [2:0]  bad_codes [6];
    int n;
    bad_codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(4'h0, v); chk(v == 32'h0, "R11 command register after reset", 64'(v), 64'h0);
    rd(4'h8, v); chk(v == 32'h0, "R11 number register after reset", 64'(v), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 link after reset", {62'd0, mdc, mdio_oe}, 64'h0);

    // R1 decode
    wr(4'h8, 32'hFFFF_1234);
    rd(4'h8, v); chk(v == 32'h0000_1234, "R1 number register readback", 64'(v), 64'h1234);
    rd(4'h4, v); chk(v == 32'h0, "R1 unmapped offset 0x4", 64'(v), 64'h0);
    rd(4'hC, v); chk(v == 32'h0, "R1 unmapped offset 0xC", 64'(v), 64'h0);

    // sweep of PHY addresses, alternating write and read, two failed reads
    for (int p = 0; p < 32; p++) begin
      run_txn(5'(p), 5'((p * 7 + 3) % 32), 16'h A5C3 ^ 16'(p * 16'h1357),
              16'h0F0F ^ 16'(p * 16'h3131), p[0], (p == 5 || p == 21),
              16'h5A00 ^ 16'(p * 16'h0321));
    end

    // R8 writes while busy
    phy_rd = 1'b0;
    wr(4'h8, 32'h0000_C0DE);
    cmd_a = {3'b000, 3'd5, 5'd9, 5'd17, 16'h1357};
    rises = 0;
    wr(4'h0, cmd_a);
    wr(4'h8, 32'h0000_FFFF);
    wr(4'h0, {3'b000, 3'd7, 5'd2, 5'd3, 16'hAAAA});
    wait_idle(n);
    rd(4'h8, v); chk(v == 32'h0000_C0DE, "R8 number register kept", 64'(v), 64'hC0DE);
    rd(4'h0, v); chk(v[28:0] == cmd_a[28:0], "R8 command register kept", 64'(v[28:0]), 64'(cmd_a[28:0]));
    chk(cap_o[127:64] == frm(2'b00, 5'd17, 5'd9, 16'hC0DE), "R8 address frame of first command",
        cap_o[127:64], frm(2'b00, 5'd17, 5'd9, 16'hC0DE));
    chk(cap_o[63:0] == frm(2'b01, 5'd17, 5'd9, 16'h1357), "R8 data frame of first command",
        cap_o[63:0], frm(2'b01, 5'd17, 5'd9, 16'h1357));
    repeat (40) @(negedge clk);
    rd(4'h0, v);
    chk(rises == 128 && v[30] == 1'b0, "R8 no second sequence", 64'(rises), 64'd128);

    // R9 other command codes
    foreach (bad_codes[i]) begin
      rd(4'h0, prior);
      rises = 0;
      wr(4'h0, {3'b000, bad_codes[i], 5'd31, 5'd31, 16'hFFFF});
      repeat (20) @(negedge clk);
      rd(4'h0, v);
      chk(v == prior && rises == 0, "R9 code ignored", {32'(rises), v}, {32'd0, prior});
    end

    // R11 reset in the middle of a sequence
    phy_rd = 1'b1; phy_ta = 1'b0;
    wr(4'h0, {3'b000, 3'd7, 5'd1, 5'd1, 16'h0000});
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd(4'h0, v);
    chk(v == 32'h0 && mdc == 1'b0 && mdio_oe == 1'b0, "R11 reset mid sequence", 64'(v), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule